// File: doc/BRIEF.md
# Clock-Ratio Peripheral Bridge

The bridge sits between a single bus master clocked by a fast bus clock and a peripheral port that only moves forward on a slower peripheral clock. The slower clock is represented by a one-cycle tick that the bridge generates itself, once every R bus cycles. R comes from a configuration input that is clamped to the range 1 to 8. The bridge accepts one command at a time: a read or write with an address and write data. It waits for the next usable peripheral edge and then holds the command on the peripheral port. It samples the peripheral's ready flag on tick cycles only, and returns a single-cycle response that carries read data.

On the request side the interface is valid/ready. The master raises `req_valid` with stable fields and keeps them until a cycle with `req_ready` high, which is the acceptance cycle. `req_ready` is high exactly when the bridge is idle, including the cycle in which the previous response is issued, so commands can follow each other with no gap. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse that the master must take. `rsp_rdata` keeps its value until the next read completes.

Latency in bus cycles is counted from the acceptance cycle to the response cycle. N is the number of tick cycles the peripheral spends on a transfer, that is, its wait ticks plus one. The position of the tick relative to acceptance decides where the latency falls within fixed bounds.

Top module: `ratio_periph_bridge`

## Requirements
- R1: `per_tick` is high for one cycle in every R cycles, where R is `cfg_ratio` clamped to 1..8: a value of 0 acts as 1 and a value above 8 acts as 8.
- R2: The ratio is taken from `cfg_ratio` only while the bridge is idle with no request pending. A change made during a transfer does not alter that transfer's timing.
- R3: A read accepted in cycle t0 responds in cycle ts + N·R + 1, where ts is the first tick cycle at or after t0. Its latency is therefore between N·R + 1 and (N+1)·R.
- R4: A write accepted in cycle t0 responds in cycle ts + N·R + 1, where ts is the first tick cycle strictly after t0. Its latency is therefore between N·R + 2 and (N+1)·R + 1.
- R5: `per_ready` is sampled only in tick cycles while `per_sel` is high. Each such tick with `per_ready` low adds one peripheral period, and `per_ready` high in any other cycle is ignored.
- R6: `req_ready` is high in every response cycle. A command accepted in that cycle follows at a spacing of max(R,2) + N·R cycles for back-to-back writes and (N+1)·R cycles for back-to-back reads.
- R7: `rsp_valid` is a single-cycle pulse that never comes in the cycle after acceptance. With R = 1 and no wait ticks, a read takes exactly 2 cycles and a write exactly 3.
- R8: `rsp_rdata` is the `per_rdata` value sampled at the ready tick of a read. It stays unchanged in every cycle without a read response, so write responses leave it as it was.
- R9: `per_write`, `per_addr` and `per_wdata` carry the fields captured at acceptance and stay stable while `per_sel` is high. `per_sel` is high from launch until the ready tick.
- R10: After reset, `req_ready` is 1, `rsp_valid` is 0, `per_sel` is 0 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio | input | 4 | Requested bus-to-peripheral clock ratio |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Command accepted when high with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Command address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, held between reads |
| per_tick | output | 1 | Peripheral clock enable, one cycle every R |
| per_sel | output | 1 | Peripheral access in progress |
| per_write | output | 1 | Direction of the current access |
| per_addr | output | 16 | Address of the current access |
| per_wdata | output | 32 | Write data of the current access |
| per_ready | input | 1 | Peripheral ready, sampled on ticks |
| per_rdata | input | 32 | Peripheral read data, sampled at the ready tick |

## Verification
Isolated commands are issued after random idle gaps for every ratio from 1 to 8, with random wait-tick counts. This places acceptance at each tick phase and separates the best-case and worst-case terms of the read and write formulas. Chains of same-type commands that are accepted in the response cycle expose the different spacing rules for reads and writes, including the two-cycle floor for writes at R = 1. Directed cases cover the clamp values, a ratio change in mid-transfer, and spurious ready pulses off the tick (with junk data on the data lines) to show that only tick samples count. The R = 1, zero-wait case pins the minimum latencies.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_ACCESS = 2'd2
  } seq_state_t;

endpackage

// File: rtl/rpb_tick_gen.sv
module rpb_tick_gen #(
  parameter int MAX_RATIO = 8,
  parameter int CFG_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_ratio,
  output logic             tick
);

  localparam int RQ_W  = $clog2(MAX_RATIO + 1);
  localparam int CNT_W = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

  logic [RQ_W-1:0]  ratio_q;
  logic [RQ_W-1:0]  ratio_next;
  logic [CNT_W-1:0] cnt;
  logic [RQ_W-1:0]  cnt_ext;

  // clamp the requested ratio into 1..MAX_RATIO
  always_comb begin
    if (cfg_ratio == '0)
      ratio_next = RQ_W'(1);
    else if (int'(cfg_ratio) > MAX_RATIO)
      ratio_next = RQ_W'(MAX_RATIO);
    else
      ratio_next = RQ_W'(cfg_ratio);
  end

  assign cnt_ext = RQ_W'(cnt);
  assign tick    = (cnt_ext + RQ_W'(1)) >= ratio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= RQ_W'(1);
      cnt     <= '0;
    end else begin
      if (load) ratio_q <= ratio_next;
      cnt <= tick ? '0 : cnt + CNT_W'(1);
    end
  end

  // checker state: cycles since last tick, and whether the ratio held since then
  logic [RQ_W-1:0] gap;
  logic            period_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= '0;
      period_ok <= 1'b0;
    end else begin
      gap <= tick ? '0 : ((gap == '1) ? gap : gap + RQ_W'(1));
      if (load && (ratio_next != ratio_q)) period_ok <= 1'b0;
      else if (tick)                       period_ok <= 1'b1;
    end
  end

  p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period_ok) |-> ((gap + RQ_W'(1)) == ratio_q));

  p_ratio_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != '0) && (int'(ratio_q) <= MAX_RATIO));

endmodule

// File: rtl/rpb_hold_reg.sv
module rpb_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/rpb_seq.sv
module rpb_seq
  import rpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic tick,
  input  logic per_ready,
  input  logic cmd_write,
  output logic req_ready,
  output logic accept,
  output logic per_sel,
  output logic rsp_valid,
  output logic rd_capture,
  output logic ratio_load
);

  seq_state_t st, st_nxt;
  logic       finish;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign per_sel    = (st == ST_ACCESS);
  assign ratio_load = (st == ST_IDLE) && !req_valid;
  assign rd_capture = finish && !cmd_write;

  always_comb begin
    st_nxt = st;
    finish = 1'b0;
    unique case (st)
      ST_IDLE: begin
        // a read may launch on the tick it arrives in; a write is staged first
        if (req_valid) st_nxt = (!req_write && tick) ? ST_ACCESS : ST_ALIGN;
      end
      ST_ALIGN: begin
        if (tick) st_nxt = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (tick && per_ready) begin
          st_nxt = ST_IDLE;
          finish = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      st        <= st_nxt;
      rsp_valid <= finish;
    end
  end

  p_min_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rsp_valid);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_offtick_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel && !tick) |=> per_sel);

  p_ready_in_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    per_sel |-> !req_ready);

  p_write_staged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !per_sel);

endmodule

// File: rtl/ratio_periph_bridge.sv
module ratio_periph_bridge #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CFG_W     = 4,
  parameter int MAX_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_ratio,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              per_tick,
  output logic              per_sel,
  output logic              per_write,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic              per_ready,
  input  logic [DATA_W-1:0] per_rdata
);

  localparam int CMD_W = 1 + ADDR_W + DATA_W;

  logic             accept;
  logic             rd_capture;
  logic             ratio_load;
  logic [CMD_W-1:0] cmd_q;

  rpb_tick_gen #(
    .MAX_RATIO (MAX_RATIO),
    .CFG_W     (CFG_W)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ratio_load),
    .cfg_ratio (cfg_ratio),
    .tick      (per_tick)
  );

  rpb_hold_reg #(.W(CMD_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (accept),
    .d     ({req_write, req_addr, req_wdata}),
    .q     (cmd_q)
  );

  assign {per_write, per_addr, per_wdata} = cmd_q;

  rpb_hold_reg #(.W(DATA_W)) u_rdata (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (rd_capture),
    .d     (per_rdata),
    .q     (rsp_rdata)
  );

  rpb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tick       (per_tick),
    .per_ready  (per_ready),
    .cmd_write  (per_write),
    .req_ready  (req_ready),
    .accept     (accept),
    .per_sel    (per_sel),
    .rsp_valid  (rsp_valid),
    .rd_capture (rd_capture),
    .ratio_load (ratio_load)
  );

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));

  p_cmd_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_sel && $past(per_sel)) |-> ($stable(per_addr) && $stable(per_wdata) && $stable(per_write)));

endmodule

// File: tb/ratio_periph_bridge_test.sv
`timescale 1ns/1ps
module ratio_periph_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_ratio = 4'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        per_tick, per_sel, per_write;
  logic [15:0] per_addr;
  logic [31:0] per_wdata;
  logic        per_ready = 1'b0;
  logic [31:0] per_rdata = '0;

  always #2.5 clk = ~clk;

  ratio_periph_bridge uut (
    .clk(clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .per_tick(per_tick), .per_sel(per_sel), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata),
    .per_ready(per_ready), .per_rdata(per_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_fn(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  // bench model state
  int  eff_r = 1;
  bit  stable = 0;
  bit  track_ok = 0;
  int  last_tick = -100;
  int  waits_cur = 0;
  bit  noise = 0;

  int          t0_a [256];
  int          exp_a[256];
  int          n_a  [256];
  int          r_a  [256];
  bit          wr_a [256];
  logic [15:0] ad_a [256];
  logic [31:0] wd_a [256];
  int issued  = 0;
  int rid     = 0;
  int prev_td = -100;

  int          scnt = 0;
  logic [15:0] got_addr = '0;
  logic [31:0] got_data = '0;
  logic        got_wr = 1'b0;
  logic [31:0] last_rd = '0;
  int          hold_err = 0;

  // peripheral model: decides ready for the tick cycle it is in
  always @(negedge clk) begin
    if (per_sel && per_tick) begin
      per_ready = (scnt >= waits_cur);
      per_rdata = rd_fn(per_addr);
      if (per_ready) begin
        scnt     = 0;
        got_addr = per_addr;
        got_data = per_wdata;
        got_wr   = per_write;
      end else begin
        scnt++;
      end
    end else begin
      per_ready = noise && per_sel;
      per_rdata = noise ? 32'hBAD0_0BAD : 32'h0;
    end
  end

  // tick and response monitor
  int id, lat, best, worst, iv, ex;
  bit w;
  always @(negedge clk) begin
    if (rst_n) begin
      if (per_tick) begin
        if (stable) begin
          if (track_ok) check(cyc - last_tick == eff_r, "R1 tick period", cyc - last_tick, eff_r);
          track_ok = 1;
        end else begin
          track_ok = 0;
        end
        last_tick = cyc;
      end
      if (rsp_valid) begin
        if (rid >= issued) begin
          check(0, "R7 unexpected response", cyc, -1);
        end else begin
          id    = rid;
          w     = wr_a[id];
          lat   = cyc - t0_a[id];
          best  = w ? n_a[id] * r_a[id] + 2 : n_a[id] * r_a[id] + 1;
          worst = w ? (n_a[id] + 1) * r_a[id] + 1 : (n_a[id] + 1) * r_a[id];
          check(cyc == exp_a[id], w ? "R4 write latency" : "R3 read latency", lat, exp_a[id] - t0_a[id]);
          check(lat >= best && lat <= worst, w ? "R4 write latency bound" : "R3 read latency bound", lat, best);
          check(got_addr == ad_a[id] && got_wr == w, "R9 peripheral address and direction", got_addr, ad_a[id]);
          check(req_ready == 1'b1, "R6 ready in response cycle", req_ready, 1);
          if (!w) begin
            check(rsp_rdata == rd_fn(ad_a[id]), "R8 read data", rsp_rdata, rd_fn(ad_a[id]));
            last_rd = rsp_rdata;
          end else begin
            check(got_data == wd_a[id], "R9 peripheral write data", got_data, wd_a[id]);
            check(rsp_rdata == last_rd, "R8 write keeps read data", rsp_rdata, last_rd);
          end
          if (id > 0 && t0_a[id] == prev_td && wr_a[id - 1] == w && r_a[id - 1] == r_a[id]) begin
            iv = cyc - prev_td;
            ex = w ? ((r_a[id] > 2 ? r_a[id] : 2) + n_a[id] * r_a[id]) : (n_a[id] + 1) * r_a[id];
            check(iv == ex, w ? "R6 back-to-back write spacing" : "R6 back-to-back read spacing", iv, ex);
          end
          prev_td = cyc;
          rid++;
        end
      end else if (rsp_rdata !== last_rd) begin
        hold_err++;
      end
    end
  end

  // issue one command starting at a negedge; returns one cycle after acceptance
  task automatic issue(input bit wr, input logic [15:0] a, input logic [31:0] d, input int wt);
    int ts;
    int k;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    if (per_tick && !wr) ts = cyc;
    else if (per_tick)   ts = cyc + eff_r;
    else                 ts = last_tick + eff_r;
    k = issued;
    t0_a[k]  = cyc;
    exp_a[k] = ts + (wt + 1) * eff_r + 1;
    n_a[k]   = wt + 1;
    r_a[k]   = eff_r;
    wr_a[k]  = wr;
    ad_a[k]  = a;
    wd_a[k]  = d;
    waits_cur = wt;
    issued++;
    @(negedge clk);
  endtask

  task automatic drain();
    req_valid = 1'b0;
    while (rid < issued) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_ratio(input int cfg, input int eff);
    cfg_ratio = 4'(cfg);
    stable = 0;
    repeat (20) @(negedge clk);
    eff_r  = eff;
    stable = 1;
    repeat (20) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R3 watchdog progress", cyc, 150000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7193));
    repeat (4) @(negedge clk);
    // R10: reset state
    check(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R10 reset rsp_valid", rsp_valid, 0);
    check(per_sel == 1'b0, "R10 reset per_sel", per_sel, 0);
    check(rsp_rdata == 32'h0, "R10 reset rsp_rdata", rsp_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: clamp cases
    set_ratio(0, 1);
    set_ratio(12, 8);
    set_ratio(3, 3);

    // R7: minimum latencies at R = 1, no wait ticks
    set_ratio(1, 1);
    issue(1'b0, 16'h0010, 32'h0, 0);
    drain();
    check(prev_td - t0_a[issued - 1] == 2, "R7 read minimum latency", prev_td - t0_a[issued - 1], 2);
    issue(1'b1, 16'h0014, 32'hCAFE_0001, 0);
    drain();
    check(prev_td - t0_a[issued - 1] == 3, "R7 write minimum latency", prev_td - t0_a[issued - 1], 3);
    // R6: write chain at R = 1 shows the two-cycle floor
    for (int i = 0; i < 3; i++) issue(1'b1, 16'h0020 + 16'(i), 32'h1000 + 32'(i), 0);
    drain();

    // R2: ratio change during a transfer is deferred
    set_ratio(2, 2);
    issue(1'b0, 16'h0100, 32'h0, 2);
    cfg_ratio = 4'd7;
    stable = 0;
    drain();
    check(prev_td == exp_a[issued - 1], "R2 ratio frozen during transfer", prev_td, exp_a[issued - 1]);
    repeat (20) @(negedge clk);
    eff_r = 7;
    stable = 1;
    repeat (20) @(negedge clk);
    issue(1'b0, 16'h0104, 32'h0, 0);
    drain();
    check(prev_td == exp_a[issued - 1], "R2 new ratio applied when idle", prev_td, exp_a[issued - 1]);

    // R5: spurious ready off the tick is ignored
    set_ratio(3, 3);
    noise = 1;
    issue(1'b0, 16'h0200, 32'h0, 2);
    drain();
    check(prev_td == exp_a[issued - 1], "R5 off-tick ready ignored (read)", prev_td, exp_a[issued - 1]);
    issue(1'b1, 16'h0204, 32'hABCD_1234, 1);
    drain();
    check(prev_td == exp_a[issued - 1], "R5 off-tick ready ignored (write)", prev_td, exp_a[issued - 1]);
    noise = 0;

    // random sweep over ratio, wait ticks and phase
    for (int r = 1; r <= 8; r++) begin
      set_ratio(r, r);
      for (int j = 0; j < 6; j++) begin
        repeat ($urandom % 9) @(negedge clk);
        noise = (($urandom % 3) == 0);
        issue(1'($urandom), 16'($urandom), $urandom, int'($urandom % 4));
        drain();
      end
      noise = 0;
      for (int j = 0; j < 3; j++) issue(1'b0, 16'($urandom), 32'h0, int'($urandom % 3));
      drain();
      for (int j = 0; j < 3; j++) issue(1'b1, 16'($urandom), $urandom, int'($urandom % 3));
      drain();
    end

    check(hold_err == 0, "R8 read data held between reads", hold_err, 0);
    check(rid == issued, "R7 every command answered once", rid, issued);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule